// File: doc/BRIEF.md
# Coprocessor load handshake responder

This block sits on the coprocessor side of a core's coprocessor port and answers instructions that load words from memory into coprocessor registers. While the core presents an instruction (issue strobe `issue_n` low), the block compares the coprocessor-number field of the presented opcode bits with its own identity. On a mismatch it leaves `absent` high, so the core takes its undefined-instruction path. On a match it pulls `absent` low and uses `busy` to stall the core until the target register is free (`reg_ready`). It then commits with one cycle of `absent` and `busy` both low.

After the commit the core drives one data word per cycle with `issue_n` high. The block counts the words against the length field and writes each word into its internal register bank, starting at the target index. On the final word it raises `absent` and `busy` together to end the burst. If the core leaves a busy-wait, for example to take an interrupt, the block returns to idle and writes nothing. The bank can be read at any time through a separate read port.

Top module: `cp_load_responder`

## Requirements
- R1: After reset the bank holds zero in every entry, and while idle with `issue_n` high both `absent` and `busy` read 1.
- R2: An issue cycle whose coprocessor-number field (`op_fields[7:4]`) differs from the configured ID (default 5) drives `absent`=1 and `busy`=1. The block stays idle, so data presented on the next cycle changes no bank entry.
- R3: An issue cycle with a matching ID and `reg_ready`=1 drives `absent`=0 and `busy`=0 in that same cycle. This is the commit.
- R4: With a matching ID and `reg_ready`=0, every issue cycle drives `absent`=0 and `busy`=1. The first issue cycle with `reg_ready`=1 commits as in R3. The pair `absent`=1, `busy`=0 never appears.
- R5: After the commit, each data cycle (`issue_n` high) drives `absent`=0 and `busy`=0, except the final word, which drives `absent`=1 and `busy`=1. The block is idle on the cycle after the final word.
- R6: The burst length is `op_fields[3:0]`+1 words (1 to 16). Word k goes to bank entry (`op_fields[11:8]`+k) mod 16.
- R7: A cycle after the commit with `issue_n` low captures nothing, does not advance the word count, and drives `absent`=0 and `busy`=0.
- R8: If `issue_n` is high in a cycle while the block is busy-waiting, the instruction is abandoned. That cycle drives `absent`=1 and `busy`=1, no bank entry changes, and the block returns to idle. This holds even if `reg_ready` is high in the same cycle.
- R9: A new instruction issued on the cycle right after a final word is handled like any other.
- R10: `rd_data` shows bank entry `rd_idx` combinationally in the default configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_n | input | 1 | Low while the core offers or busy-waits an instruction; high during data cycles |
| op_fields | input | 12 | Opcode bits: [3:0] length-1, [7:4] coprocessor number, [11:8] target index |
| reg_ready | input | 1 | Target register is free to accept data |
| wdata | input | 32 | Data word from memory |
| absent | output | 1 | Coprocessor absent handshake line |
| busy | output | 1 | Coprocessor busy handshake line |
| rd_idx | input | 4 | Bank read index |
| rd_data | output | 32 | Bank read data |

## Verification
The core abandoning a busy-wait and the register becoming ready can fall in the same cycle. The bench provokes this by raising `reg_ready` on the very cycle it lifts the strobe, with a data word on the bus. It judges the outcome by the idle handshake values in that cycle and by an unchanged bank on readback. A second collision is a final word followed directly by a new issue. It is judged by the handshake of the second burst and by both bursts landing in the bank.

// File: rtl/cpl_pkg.sv
`timescale 1ns/1ps
package cpl_pkg;
   typedef enum logic [1:0] {
      CPL_IDLE = 2'd0,
      CPL_WAIT = 2'd1,
      CPL_XFER = 2'd2
   } cpl_state_e;
endpackage

// File: rtl/cpl_decode.sv
`timescale 1ns/1ps
module cpl_decode #(
   parameter int OP_W      = 12,
   parameter int LEN_LSB   = 0,
   parameter int LEN_W     = 4,
   parameter int CPNUM_LSB = 4,
   parameter int CPNUM_W   = 4,
   parameter int CP_ID     = 5,
   parameter int IDX_LSB   = 8,
   parameter int IDX_W     = 4
) (
   input  logic [OP_W-1:0]  op_fields,
   output logic             cp_hit,
   output logic [IDX_W-1:0] base_idx,
   output logic [LEN_W-1:0] len_m1
);
   if (LEN_LSB + LEN_W > OP_W) begin : g_bad_len
      $error("length field exceeds opcode width");
   end
   if (CPNUM_LSB + CPNUM_W > OP_W) begin : g_bad_cp
      $error("coprocessor number field exceeds opcode width");
   end
   if (IDX_LSB + IDX_W > OP_W) begin : g_bad_idx
      $error("index field exceeds opcode width");
   end
   if (CP_ID >= (1 << CPNUM_W)) begin : g_bad_id
      $error("coprocessor ID does not fit its field");
   end

   assign cp_hit   = (op_fields[CPNUM_LSB +: CPNUM_W] == CPNUM_W'(CP_ID));
   assign base_idx = op_fields[IDX_LSB +: IDX_W];
   assign len_m1   = op_fields[LEN_LSB +: LEN_W];
endmodule

// File: rtl/cpl_ctrl.sv
`timescale 1ns/1ps
module cpl_ctrl
   import cpl_pkg::*;
#(
   parameter int IDX_W = 4,
   parameter int LEN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue_n,
   input  logic             reg_ready,
   input  logic             cp_hit,
   input  logic [IDX_W-1:0] base_in,
   input  logic [LEN_W-1:0] len_m1_in,
   output logic             absent,
   output logic             busy,
   output logic             we,
   output logic [IDX_W-1:0] widx,
   output cpl_state_e       st,
   output logic             at_last
);
   cpl_state_e       st_q, st_d;
   logic [LEN_W-1:0] cnt_q, len_q;
   logic [IDX_W-1:0] base_q;
   logic             accept;

   assign st      = st_q;
   assign at_last = (cnt_q == len_q);
   assign widx    = base_q + IDX_W'(cnt_q);
   assign accept  = (st_q == CPL_IDLE) && !issue_n && cp_hit;

   always_comb begin
      absent = 1'b1;
      busy   = 1'b1;
      we     = 1'b0;
      st_d   = st_q;
      unique case (st_q)
         CPL_IDLE: begin
            if (accept) begin
               absent = 1'b0;
               busy   = !reg_ready;
               st_d   = reg_ready ? CPL_XFER : CPL_WAIT;
            end
         end
         CPL_WAIT: begin
            if (issue_n) begin
               st_d = CPL_IDLE;
            end else begin
               absent = 1'b0;
               busy   = !reg_ready;
               if (reg_ready) st_d = CPL_XFER;
            end
         end
         CPL_XFER: begin
            if (issue_n) begin
               we     = 1'b1;
               absent = at_last;
               busy   = at_last;
               if (at_last) st_d = CPL_IDLE;
            end else begin
               absent = 1'b0;
               busy   = 1'b0;
            end
         end
         default: st_d = CPL_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= CPL_IDLE;
         cnt_q  <= '0;
         len_q  <= '0;
         base_q <= '0;
      end else begin
         st_q <= st_d;
         if (accept) begin
            base_q <= base_in;
            len_q  <= len_m1_in;
            cnt_q  <= '0;
         end else if (we) begin
            cnt_q <= cnt_q + LEN_W'(1);
         end
      end
   end
endmodule

// File: rtl/cpl_bank.sv
`timescale 1ns/1ps
module cpl_bank #(
   parameter int DATA_W = 32,
   parameter int NREG   = 16,
   parameter int IDX_W  = 4,
   parameter bit RD_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem [NREG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) mem[i] <= '0;
      end else if (we) begin
         mem[widx] <= wdata;
      end
   end

   if (RD_REG) begin : g_rd_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_data <= '0;
         else        rd_data <= mem[rd_idx];
      end
   end else begin : g_rd_comb
      assign rd_data = mem[rd_idx];
   end
endmodule

// File: rtl/cp_load_responder.sv
`timescale 1ns/1ps
module cp_load_responder
   import cpl_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int NREG      = 16,
   parameter int LEN_W     = 4,
   parameter int CPNUM_W   = 4,
   parameter int CP_ID     = 5,
   parameter int LEN_LSB   = 0,
   parameter int CPNUM_LSB = LEN_LSB + LEN_W,
   parameter int IDX_LSB   = CPNUM_LSB + CPNUM_W,
   parameter bit RD_REG    = 1'b0,
   localparam int IDX_W    = $clog2(NREG),
   localparam int OP_W     = IDX_LSB + IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_n,
   input  logic [OP_W-1:0]   op_fields,
   input  logic              reg_ready,
   input  logic [DATA_W-1:0] wdata,
   output logic              absent,
   output logic              busy,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   if ((1 << IDX_W) != NREG || NREG < 2) begin : g_bad_nreg
      $error("NREG must be a power of two of at least 2");
   end
   if (LEN_W < 1 || DATA_W < 1) begin : g_bad_w
      $error("widths must be positive");
   end

   logic             cp_hit;
   logic [IDX_W-1:0] base_idx;
   logic [LEN_W-1:0] len_m1;
   logic             bank_we;
   logic [IDX_W-1:0] bank_widx;
   cpl_state_e       st;
   logic             at_last;

   cpl_decode #(
      .OP_W(OP_W), .LEN_LSB(LEN_LSB), .LEN_W(LEN_W),
      .CPNUM_LSB(CPNUM_LSB), .CPNUM_W(CPNUM_W), .CP_ID(CP_ID),
      .IDX_LSB(IDX_LSB), .IDX_W(IDX_W)
   ) u_dec (
      .op_fields(op_fields), .cp_hit(cp_hit),
      .base_idx(base_idx), .len_m1(len_m1)
   );

   cpl_ctrl #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .issue_n(issue_n), .reg_ready(reg_ready),
      .cp_hit(cp_hit), .base_in(base_idx), .len_m1_in(len_m1),
      .absent(absent), .busy(busy), .we(bank_we), .widx(bank_widx),
      .st(st), .at_last(at_last)
   );

   cpl_bank #(.DATA_W(DATA_W), .NREG(NREG), .IDX_W(IDX_W), .RD_REG(RD_REG)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(bank_we), .widx(bank_widx),
      .wdata(wdata), .rd_idx(rd_idx), .rd_data(rd_data)
   );
endmodule

// File: rtl/cpl_checker.sv
`timescale 1ns/1ps
module cpl_checker
   import cpl_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       issue_n,
   input logic       absent,
   input logic       busy,
   input logic       cp_hit,
   input logic       bank_we,
   input cpl_state_e st
);
   AST_MISS_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
      (st == CPL_IDLE && !issue_n && !cp_hit) |-> (absent && busy)); // R2
   AST_MISS_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == CPL_IDLE && !issue_n && !cp_hit) |=> (st == CPL_IDLE)); // R2
   AST_COMMIT_TO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      (st != CPL_XFER && !issue_n && !absent && !busy) |=> (st == CPL_XFER)); // R3
   AST_STALL_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      (!issue_n && !absent && busy) |=> (st == CPL_WAIT)); // R4
   AST_NO_HALF_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      !(absent && !busy)); // R4
   AST_FINAL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (st == CPL_XFER && issue_n && absent && busy) |=> (st == CPL_IDLE)); // R5
   AST_GAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (st == CPL_XFER && !issue_n) |=> (st == CPL_XFER)); // R7
   AST_ABANDON_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == CPL_WAIT && issue_n) |-> (!bank_we && absent && busy)); // R8
   AST_ABANDON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == CPL_WAIT && issue_n) |=> (st == CPL_IDLE)); // R8
endmodule

bind cp_load_responder cpl_checker u_chk (
   .clk(clk), .rst_n(rst_n), .issue_n(issue_n), .absent(absent),
   .busy(busy), .cp_hit(cp_hit), .bank_we(bank_we), .st(st)
);

// File: tb/tb_cp_load_responder.sv
`timescale 1ns/1ps
module tb_cp_load_responder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_n = 1'b1;
   logic [11:0] op_fields = '0;
   logic        reg_ready = 1'b0;
   logic [31:0] wdata = '0;
   logic        absent, busy;
   logic [3:0]  rd_idx = '0;
   logic [31:0] rd_data;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int seq = 0;
   logic [31:0] model [16];

   cp_load_responder dut (
      .clk(clk), .rst_n(rst_n), .issue_n(issue_n), .op_fields(op_fields),
      .reg_ready(reg_ready), .wdata(wdata), .absent(absent), .busy(busy),
      .rd_idx(rd_idx), .rd_data(rd_data)
   );

   always #2 clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic chk_hs(input string req, input logic ea, input logic eb);
      chk({req, " absent"}, {31'd0, absent}, {31'd0, ea});
      chk({req, " busy"}, {31'd0, busy}, {31'd0, eb});
   endtask

   task automatic check_bank(input string req);
      for (int i = 0; i < 16; i++) begin
         rd_idx = 4'(i);
         #0.1;
         chk({req, " R10 bank entry"}, rd_data, model[i]);
      end
   endtask

   task automatic idle_cycle();
      @(negedge clk);
      issue_n = 1'b1; reg_ready = 1'b0; wdata = 32'hBAD0_BAD0;
      #1 chk_hs("R1 idle", 1'b1, 1'b1);
   endtask

   // waitn: stalled issue cycles before commit; gapk: data index preceded by a strobe-low cycle (-1 none)
   task automatic do_xfer(input logic [3:0] base, input logic [3:0] lenf, input int waitn, input int gapk);
      logic [31:0] pat;
      @(negedge clk);
      issue_n = 1'b0; op_fields = {base, 4'd5, lenf}; reg_ready = (waitn == 0);
      #1 chk_hs((waitn == 0) ? "R3 commit" : "R4 stall", 1'b0, waitn != 0);
      for (int w = 1; w <= waitn; w++) begin
         @(negedge clk);
         reg_ready = (w == waitn);
         #1 chk_hs("R4 busy-wait", 1'b0, w != waitn);
      end
      for (int k = 0; k <= int'(lenf); k++) begin
         if (k == gapk) begin
            @(negedge clk);
            issue_n = 1'b0; reg_ready = 1'b0; wdata = 32'hDEAD_0000;
            #1 chk_hs("R7 gap", 1'b0, 1'b0);
         end
         @(negedge clk);
         seq++;
         pat = {4'(base), 4'(lenf), 8'(k), 16'(seq)};
         issue_n = 1'b1; wdata = pat;
         #1 chk_hs("R5 data", k == int'(lenf), k == int'(lenf));
         model[(int'(base) + k) & 15] = pat;
      end
   endtask

   initial begin
      for (int i = 0; i < 16; i++) model[i] = '0;
      #9 rst_n = 1'b1;
      // R1: reset state
      idle_cycle();
      check_bank("R1 reset");

      // R6 sweep over length, base and stall depth (with wrap-around)
      for (int lf = 0; lf < 16; lf++) begin
         for (int b = 0; b < 2; b++) begin
            for (int wn = 0; wn < 3; wn++) begin
               do_xfer(4'((lf * 7 + b * 9 + wn * 5) & 15), 4'(lf), wn, (wn == 2) ? lf / 2 : -1);
               idle_cycle();
               check_bank("R6 sweep");
            end
         end
      end

      // R2: ID mismatch, then data offered on the next cycle
      @(negedge clk);
      issue_n = 1'b0; op_fields = {4'd2, 4'd3, 4'd4}; reg_ready = 1'b1;
      #1 chk_hs("R2 mismatch issue", 1'b1, 1'b1);
      @(negedge clk);
      issue_n = 1'b1; wdata = 32'h1234_5678;
      #1 chk_hs("R2 after mismatch", 1'b1, 1'b1);
      idle_cycle();
      check_bank("R2 no write");

      // R8: abandon during busy-wait with readiness in the same cycle
      @(negedge clk);
      issue_n = 1'b0; op_fields = {4'd6, 4'd5, 4'd3}; reg_ready = 1'b0;
      #1 chk_hs("R4 stall", 1'b0, 1'b1);
      @(negedge clk);
      #1 chk_hs("R4 stall", 1'b0, 1'b1);
      @(negedge clk);
      issue_n = 1'b1; reg_ready = 1'b1; wdata = 32'hCAFE_F00D;
      #1 chk_hs("R8 abandon", 1'b1, 1'b1);
      @(negedge clk);
      #1 chk_hs("R8 after abandon", 1'b1, 1'b1);
      idle_cycle();
      check_bank("R8 no write");
      do_xfer(4'd6, 4'd3, 1, -1);
      idle_cycle();
      check_bank("R8 recovery");

      // R9: back-to-back instructions
      do_xfer(4'd14, 4'd2, 0, -1);
      do_xfer(4'd1, 4'd1, 2, 0);
      do_xfer(4'd9, 4'd0, 0, -1);
      idle_cycle();
      check_bank("R9 back-to-back");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule